// File: doc/BRIEF.md
# Address Translation Buffer with Page-Table Refill

This block sits between a processor and memory and turns a virtual address into a physical address. Pages are 4 KB: the low 12 address bits are the page offset and go through unchanged, and the bits above them form the virtual page number (VPN). A small fully associative store keeps recent translations. Any VPN can sit in any slot.

When the VPN is in the store, the physical address comes back one cycle after the request is accepted and memory is not touched. When it is missing, the block reads one page-table word from a flat table in memory, at `pt_base + VPN*4`, and waits for the reply. A word marked present is installed and then used to form the address. A word marked absent raises a page fault, and nothing is installed.

A single-cycle flush empties the store. While a refill is outstanding the block does not accept new requests.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `rsp_fault` and `mem_rd_valid` are 0, and the store is empty, so the first access to any page misses.
- R2: The physical address is `{frame, vaddr[11:0]}`. The VPN is `vaddr[31:12]`.
- R3: A request that hits gives `rsp_valid` for one cycle in the cycle right after the accepting clock edge (latency 1), and issues no memory read.
- R4: A request that misses raises `mem_rd_valid` in its accepting cycle, with `mem_rd_addr = pt_base + VPN*4`. Exactly one read is issued per miss.
- R5: A page-table word holds the present flag in bit 0 and the frame number in bits 31:12. If the reply is present, the response follows the cycle of `mem_rsp_valid`. Miss latency is therefore 1 + D, where D is the number of cycles from the read cycle to the reply cycle. The entry is installed.
- R6: If the reply has bit 0 clear, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0, and nothing is installed. A later access to the same page misses again.
- R7: From the accepting edge of a miss until its response, `req_ready` is 0 and no request is taken.
- R8: Installs go to slots 0, 1, ..., N-1 in turn and then wrap. Only present refills advance the slot pointer.
- R9: `flush` empties the store in one cycle, and `req_ready` is 0 in a cycle with `flush` high.
- R10: `rsp_fault` is only ever high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the translation store |
| pt_base | input | 32 | Byte address of the flat page table |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault for the current result |
| mem_rd_valid | output | 1 | Page-table read request |
| mem_rd_addr | output | 32 | Page-table word address |
| mem_rsp_valid | input | 1 | Page-table read data valid |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
The bench sets the store to four slots. It replays a request sequence that fills every slot and then wraps the victim pointer. A design that evicted in the wrong order, or let a faulting refill take a slot, would turn an expected hit into a miss, and the read counter and latency check would expose it.

Absent entries are requested twice in a row. A block that installed faults would answer the second request as a hit with a garbage frame. Memory delays of one to three cycles separate a correct miss latency from an off-by-one.

Flush is checked twice: for blocking acceptance in its own cycle, and for invalidating a page that was resident. A changed `pt_base` shows whether the read address follows the base register.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int PAGE_W = 12;

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PFN_W = PA_W - PAGE_W;
    localparam int PTE_W = PA_W;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [PAGE_W-1:0] off_t;
    typedef logic [PA_W-1:0]   pa_t;

    typedef struct packed {
        pfn_t              frame;
        logic [PAGE_W-2:0] spare;
        logic              present;
    } pte_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } walk_state_t;

    function automatic vpn_t vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:PAGE_W];
    endfunction

    function automatic off_t off_of(input logic [VA_W-1:0] va);
        return va[PAGE_W-1:0];
    endfunction

    function automatic pa_t join_pa(input pfn_t frame, input off_t off);
        return {frame, off};
    endfunction

    function automatic pa_t pte_addr(input pa_t base, input vpn_t vpn);
        return base + {{(PA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  vpn_t             lk_vpn,
    output logic             lk_hit,
    output pfn_t             lk_pfn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  vpn_t             wr_vpn,
    input  pfn_t             wr_pfn
);

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    vpn_t               tag_q [ENTRIES];
    pfn_t               frm_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        assign sel      = wr_en && (wr_idx == IDX_W'(i));
        assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                frm_q[i] <= '0;
            end else if (sel) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= wr_vpn;
                frm_q[i] <= wr_pfn;
            end else if (flush) begin
                vld_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_pfn = lk_pfn | frm_q[i];
        end
    end

    assign lk_hit = |match;

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_miss_ctrl.sv
module tlb_miss_ctrl
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  pa_t              pt_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic             hit,
    input  pfn_t             hit_pfn,
    output logic             mem_rd_valid,
    output pa_t              mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output pa_t              rsp_paddr,
    output logic             rsp_fault,
    output logic             fill_en,
    output vpn_t             fill_vpn,
    output pfn_t             fill_pfn
);

    walk_state_t state_q;
    vpn_t        pend_vpn_q;
    off_t        pend_off_q;
    pte_t        pte;
    logic        accept;
    logic        reply;

    assign pte       = pte_t'(mem_rsp_data);
    assign req_ready = (state_q == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign reply     = (state_q == ST_WAIT) && mem_rsp_valid;

    assign mem_rd_valid = accept && !hit;
    assign mem_rd_addr  = pte_addr(pt_base, vpn_of(req_vaddr));

    assign fill_en  = reply && pte.present;
    assign fill_vpn = pend_vpn_q;
    assign fill_pfn = pte.frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_vpn_q <= '0;
            pend_off_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_paddr <= join_pa(hit_pfn, off_of(req_vaddr));
                        end else begin
                            state_q    <= ST_WAIT;
                            pend_vpn_q <= vpn_of(req_vaddr);
                            pend_off_q <= off_of(req_vaddr);
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        if (pte.present) begin
                            rsp_paddr <= join_pa(pte.frame, pend_off_q);
                        end else begin
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic             hit;
    pfn_t             hit_pfn;
    logic             fill_en;
    vpn_t             fill_vpn;
    pfn_t             fill_pfn;
    logic [IDX_W-1:0] victim;

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .lk_vpn (vpn_of(req_vaddr)),
        .lk_hit (hit),
        .lk_pfn (hit_pfn),
        .wr_en  (fill_en),
        .wr_idx (victim),
        .wr_vpn (fill_vpn),
        .wr_pfn (fill_pfn)
    );

    tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk (clk),
        .rst (rst),
        .adv (fill_en),
        .idx (victim)
    );

    tlb_miss_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .pt_base       (pt_base),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .hit           (hit),
        .hit_pfn       (hit_pfn),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn)
    );

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic clk,
    input logic rst,
    input logic flush,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_fault,
    input logic mem_rd_valid,
    input logic mem_rsp_valid
);

    AST_FAULT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid); // R10

    AST_READ_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (req_valid && req_ready)); // R4

    AST_BUSY_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !req_ready); // R7

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        flush |-> !req_ready); // R9

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid))); // R5

    AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !flush) |-> req_ready); // R7

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 4;

    typedef struct packed {
        logic [19:0] vpn;
        logic [11:0] off;
        logic        miss;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{20'h00001, 12'h123, 1'b1},
        '{20'h00001, 12'hFFF, 1'b0},
        '{20'h00002, 12'h000, 1'b1},
        '{20'h00007, 12'h444, 1'b1},
        '{20'h00007, 12'h445, 1'b1},
        '{20'h00003, 12'h0A0, 1'b1},
        '{20'h00004, 12'h777, 1'b1},
        '{20'h00002, 12'h010, 1'b0},
        '{20'h00005, 12'h5A5, 1'b1},
        '{20'h00001, 12'h001, 1'b1},
        '{20'h00003, 12'h0B0, 1'b0},
        '{20'h00002, 12'h020, 1'b1},
        '{20'h00004, 12'h778, 1'b0},
        '{20'h00003, 12'h0C0, 1'b1},
        '{20'hFFFFE, 12'hABC, 1'b1},
        '{20'hFFFFE, 12'h321, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int bad_addr = 0;
    int mem_delay = 1;
    logic [19:0] exp_vpn = '0;
    logic        mem_pend = 1'b0;
    int          mem_cnt = 0;
    logic [19:0] mem_vpn = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate #(.ENTRIES(N_ENT)) u_tlb_xlate (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .pt_base       (pt_base),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // Reference page table: absent when low three VPN bits are all ones.
    function automatic logic [31:0] ref_pte(input logic [19:0] vpn);
        logic [19:0] frame;
        frame = vpn ^ 20'h3C5A1;
        return {frame, 11'd0, (vpn[2:0] != 3'd7)};
    endfunction

    // Memory model: reply D cycles after the read cycle.
    always @(posedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
        if (mem_rd_valid) begin
            reads <= reads + 1;
            if (mem_rd_addr != pt_base + {10'd0, exp_vpn, 2'b00}) bad_addr <= bad_addr + 1;
            if (mem_delay == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= ref_pte(exp_vpn);
            end else begin
                mem_pend <= 1'b1;
                mem_cnt  <= mem_delay - 2;
                mem_vpn  <= exp_vpn;
            end
        end else if (mem_pend) begin
            if (mem_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= ref_pte(mem_vpn);
                mem_pend      <= 1'b0;
            end else begin
                mem_cnt <= mem_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_req(input logic [19:0] vpn, input logic [11:0] off,
                          input bit miss, input int d);
        int  lat;
        int  r0;
        int  b0;
        bit  rdy_first;
        bit  flt;
        logic [31:0] pte;
        @(negedge clk);
        exp_vpn   = vpn;
        mem_delay = d;
        r0 = reads;
        b0 = bad_addr;
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        chk(req_ready == 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rdy_first = req_ready;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        pte = ref_pte(vpn);
        flt = miss && !pte[0];
        if (miss) begin
            chk(lat == 1 + d, "R5 miss latency", 64'(lat), 64'(1 + d));
            chk(reads - r0 == 1, "R4 one read per miss", 64'(reads - r0), 64'd1);
            chk(bad_addr == b0, "R4 read address", 64'(bad_addr - b0), 64'd0);
            chk(rdy_first == 1'b0, "R7 busy during miss", 64'(rdy_first), 64'd0);
        end else begin
            chk(lat == 1, "R3 hit latency", 64'(lat), 64'd1);
            chk(reads == r0, "R3 no read on hit", 64'(reads - r0), 64'd0);
        end
        chk(rsp_fault == flt, flt ? "R6 fault raised" : "R6 no fault", 64'(rsp_fault), 64'(flt));
        if (flt)
            chk(rsp_paddr == 32'd0, "R6 zero address on fault", 64'(rsp_paddr), 64'd0);
        else
            chk(rsp_paddr == {pte[31:12], off}, "R2 physical address",
                64'(rsp_paddr), 64'({pte[31:12], off}));
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 single-cycle response", 64'(rsp_valid), 64'd0);
        chk(rsp_fault == 1'b0, "R10 fault only with response", 64'(rsp_fault), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        chk(rsp_fault == 1'b0, "R1 no fault after reset", 64'(rsp_fault), 64'd0);
        chk(mem_rd_valid == 1'b0, "R1 no read after reset", 64'(mem_rd_valid), 64'd0);

        // Vector walk: R8 round-robin order decides which entries hit.
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].vpn, VECS[i].off, VECS[i].miss, 1 + (i % 3));
        end

        // R9 flush blocks acceptance in its own cycle
        @(negedge clk);
        flush     = 1'b1;
        req_valid = 1'b1;
        req_vaddr = {20'h00004, 12'h000};
        #1;
        chk(req_ready == 1'b0, "R9 not ready during flush", 64'(req_ready), 64'd0);
        chk(mem_rd_valid == 1'b0, "R9 no read during flush", 64'(mem_rd_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        flush     = 1'b0;
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R9 flush cycle gives no response", 64'(rsp_valid), 64'd0);
        // R9 page resident before flush now misses
        do_req(20'hFFFFE, 12'h555, 1'b1, 2);
        do_req(20'hFFFFE, 12'h556, 1'b0, 2);

        // R4 read address follows a new base
        @(negedge clk);
        pt_base = 32'h0008_0000;
        flush   = 1'b1;
        @(negedge clk);
        flush   = 1'b0;
        do_req(20'h00009, 12'h00F, 1'b1, 3);
        // R6 repeated fault after a base change still misses
        do_req(20'h0000F, 12'h100, 1'b1, 1);
        do_req(20'h0000F, 12'h101, 1'b1, 1);
        do_req(20'h00009, 12'h0F0, 1'b0, 1);

        finish_run();
    end

endmodule